// File: doc/BRIEF.md
# Shift and Rotate Unit with Separate Extend Flag

This block performs the shift and rotate operations of a 32-bit integer core in one pass. The count is applied all at once rather than one position per cycle. It takes an operand, a 6-bit count, a 3-bit operation code, a size code and the current extend flag. One clock edge later it presents the result and five flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C).

Only the low byte, word or long word of the operand is shifted, and the bits above that window are returned unchanged. The extend flag is kept apart from carry. This lets multi-word shifts chain through X while branch logic reads C. The two rotate-through-extend operations treat X as one extra bit above the window, so the ring is 9, 17 or 33 bits wide.

Top module: `shift_rot_unit`

## Requirements
- R1: With `rst_n` low, the result and all flags are zero. Otherwise the outputs show the result of the inputs sampled at the previous rising clock edge.
- R2: `op_i` encodes the operation as follows: 0 arithmetic right, 1 arithmetic left, 2 logical right, 3 logical left, 4 rotate right through X, 5 rotate left through X, 6 rotate right, 7 rotate left. For the logical shifts, vacated positions are filled with zeros. For a nonzero count, C and X both take the last bit shifted out of the window.
- R3: An arithmetic right shift fills the vacated positions with the window's top bit. For a nonzero count, C and X take the last bit shifted out, and this equals the sign once the count reaches the window width.
- R4: An arithmetic left shift fills with zeros like the logical left shift. V is set when the window's top bit takes more than one value at any point during the shift, and is clear otherwise.
- R5: The plain rotates (op 6 and 7) rotate the window by the count modulo its width. For a nonzero count, C is the last bit carried around. X keeps its input value.
- R6: The rotates through X (op 4 and 5) rotate the ring formed by the window with X above its top bit, by the count modulo the window width plus one. X and C both take the ring's extra bit after the rotation.
- R7: `size_i` selects the window: 0 is bits 7:0, 1 is bits 15:0, and 2 or 3 is bits 31:0. Result bits above the window equal the operand's bits.
- R8: With a count of zero, the result equals the operand and X keeps its input value. C is cleared, except for op 4 and 5, where C takes the input X.
- R9: N is the top bit of the result window and Z is set when the result window is all zeros. V is clear for every operation other than op 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_i | input | 32 | Operand |
| cnt_i | input | 6 | Shift or rotate count |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Window size code |
| x_i | input | 1 | Current extend flag |
| res_o | output | 32 | Registered result |
| x_o | output | 1 | New extend flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The block keeps no state beyond the output register, so a wrong width mask, count reduction or fill choice appears in the very next result as a bit error. That error shows inside the window or in the preserved upper bits. A wrong choice of the last bit shifted out shows only in C and X. The counts 0, 1, window width minus one, width, width plus one and 63 are where the modulo, fill and carry logic change behaviour. These counts are driven for every operation and size, and random vectors cover the rest. All of it is compared each cycle against a model that moves one bit per step.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opnd_i,
  input  logic [5:0]    cnt_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic          x_i,
  output logic [DW-1:0] res_o,
  output logic          x_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o
);
  localparam int EW = 3 * DW;

  logic [DW-1:0] wmask, topbit, a, sx, fill, r, mtop, rot;
  logic [5:0]    wbits, wm1, rl, rw, rm, rl2;
  logic [EW-1:0] shl;
  logic signed [EW:0] shr;
  logic [DW:0]   ring, rmask, rr;
  logic          left, cnt0, shl_c, asl_v, rox_x, c, x, v;
  logic [1:0]    kind;

  always_comb begin
    case (size_i)
      2'd0:    begin wmask = DW'(8'hFF);   wbits = 6'd8;  end
      2'd1:    begin wmask = DW'(16'hFFFF); wbits = 6'd16; end
      default: begin wmask = '1;           wbits = 6'(DW); end
    endcase
  end

  assign kind   = op_i[2:1];
  assign left   = op_i[0];
  assign cnt0   = (cnt_i == 6'd0);
  assign topbit = wmask & ~(wmask >> 1);
  assign a      = opnd_i & wmask;
  assign sx     = (|(a & topbit)) ? (a | ~wmask) : a;
  assign fill   = (kind == 2'd0) ? sx : a;

  assign shl = {{(EW-DW){1'b0}}, a} << cnt_i;
  assign shr = $signed({(kind == 2'd0) & sx[DW-1], fill, {(EW-DW){1'b0}}}) >>> cnt_i;

  always_comb begin
    case (size_i)
      2'd0:    shl_c = shl[8];
      2'd1:    shl_c = shl[16];
      default: shl_c = shl[DW];
    endcase
  end

  assign mtop  = wmask & ~(wmask >> ({1'b0, cnt_i} + 7'd1));
  assign asl_v = cnt0 ? 1'b0 :
                 ({1'b0, cnt_i} >= {1'b0, wbits}) ? (|a) :
                 ((|(a & mtop)) && ((a & mtop) != mtop));

  assign wm1 = wbits - 6'd1;
  assign rl  = left ? (cnt_i & wm1) : ((wbits - (cnt_i & wm1)) & wm1);
  assign rot = ((a << rl) | (a >> (wbits - rl))) & wmask;

  assign rw    = wbits + 6'd1;
  assign rm    = cnt_i % rw;
  assign rl2   = (left || rm == 6'd0) ? rm : (rw - rm);
  assign ring  = {1'b0, a} | ({{DW{1'b0}}, x_i} << wbits);
  assign rmask = {1'b0, wmask} | ({{DW{1'b0}}, 1'b1} << wbits);
  assign rr    = ((ring << rl2) | (ring >> (rw - rl2))) & rmask;
  assign rox_x = |(rr & ({{DW{1'b0}}, 1'b1} << wbits));

  always_comb begin
    v = 1'b0;
    case (kind)
      2'd0, 2'd1: begin
        r = left ? (shl[DW-1:0] & wmask) : (shr[EW-1 -: DW] & wmask);
        c = cnt0 ? 1'b0 : (left ? shl_c : shr[EW-DW-1]);
        x = cnt0 ? x_i : c;
        v = (kind == 2'd0 && left) ? asl_v : 1'b0;
      end
      2'd2: begin
        r = rr[DW-1:0] & wmask;
        c = rox_x;
        x = rox_x;
      end
      default: begin
        r = rot;
        c = cnt0 ? 1'b0 : (left ? rot[0] : (|(rot & topbit)));
        x = x_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      {x_o, n_o, z_o, v_o, c_o} <= '0;
    end else begin
      res_o <= (opnd_i & ~wmask) | r;
      x_o   <= x;
      n_o   <= |(r & topbit);
      z_o   <= (r == '0);
      v_o   <= v;
      c_o   <= c;
    end
  end

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(size_i) == 2'd0 |-> res_o[DW-1:8] == $past(opnd_i[DW-1:8])); // R7
  AST_V_ASL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_i) != 3'd1 |-> !v_o); // R9
  AST_ROT_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_i[2:1]) == 2'd3 |-> x_o == $past(x_i)); // R5
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cnt_i) == 6'd0 && $past(op_i[2:1]) != 2'd2
    |-> !c_o && x_o == $past(x_i) && res_o == $past(opnd_i)); // R8
  AST_ROX_CX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_i[2:1]) == 2'd2 |-> c_o == x_o); // R6
  AST_ASL_NO_V_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_i) == 3'd1 && $past(opnd_i) == '0 |-> !v_o && z_o); // R4
endmodule

// File: tb/shift_rot_unit_tb.sv
`timescale 1ns/1ps
module shift_rot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd = '0;
  logic [5:0]  cnt = '0;
  logic [2:0]  op = '0;
  logic [1:0]  sz = '0;
  logic        xin = 1'b0;
  logic [31:0] res;
  logic        xo, no, zo, vo, co;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opnd_i(opnd), .cnt_i(cnt), .op_i(op),
    .size_i(sz), .x_i(xin), .res_o(res), .x_o(xo), .n_o(no), .z_o(zo),
    .v_o(vo), .c_o(co)
  );

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [36:0] model(input logic [31:0] d, input logic [5:0] k,
                                        input logic [2:0] o, input logic [1:0] s,
                                        input logic xi);
    int w = width_of(s);
    logic [31:0] v = d;
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    logic x = xi, c = 1'b0, vf = 1'b0, ob, ib;
    for (int i = 0; i < int'(k); i++) begin
      if (o[0]) begin
        ob = v[w-1];
        case (o[2:1]) 2'd0, 2'd1: ib = 1'b0; 2'd2: ib = x; default: ib = ob; endcase
        for (int j = w - 1; j > 0; j--) v[j] = v[j-1];
        v[0] = ib;
        if (o == 3'd1 && v[w-1] != ob) vf = 1'b1;
      end else begin
        ob = v[0];
        case (o[2:1]) 2'd0: ib = v[w-1]; 2'd1: ib = 1'b0; 2'd2: ib = x; default: ib = ob; endcase
        for (int j = 0; j < w - 1; j++) v[j] = v[j+1];
        v[w-1] = ib;
      end
      c = ob;
      if (o[2:1] != 2'd3) x = ob;
    end
    if (k == 6'd0) c = (o[2:1] == 2'd2) ? xi : 1'b0;
    return {v, x, v[w-1], (v & m) == 32'd0, vf, c};
  endfunction

  function automatic string tag_of(input logic [2:0] o, input logic [5:0] k);
    if (k == 6'd0) return "R8";
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R2";
      3'd4, 3'd5: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] d, input logic [5:0] k, input logic [2:0] o,
                     input logic [1:0] s, input logic xi);
    logic [36:0] e;
    logic [31:0] m;
    @(negedge clk);
    opnd = d; cnt = k; op = o; sz = s; xin = xi;
    e = model(d, k, o, s, xi);
    m = (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    @(negedge clk);  // result registered at the edge between (R1)
    check(tag_of(o, k), {5'd0, res}, {5'd0, e[36:5]});
    check((o == 3'd1 && k != 6'd0) ? "R4" : "R9", {32'd0, xo, no, zo, vo, co}, {32'd0, e[4:0]});
    if (s != 2'd2) check("R7", {5'd0, res & ~m}, {5'd0, d & ~m});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1", {res, xo, no, zo, vo, co}, 37'd0);
    opnd = 32'hDEAD_BEEF; cnt = 6'd3; op = 3'd3; sz = 2'd2;
    #1;
    check("R1", {res, xo, no, zo, vo, co}, 37'd0);
    @(negedge clk);
    check("R1", {res, xo, no, zo, vo, co}, 37'd0);
    rst_n = 1'b1;

    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 3; s++) begin
        automatic int w = width_of(2'(s));
        automatic int ks[6] = '{0, 1, w - 1, w, w + 1, 63};
        foreach (ks[i]) begin
          run(32'hA5C3_8181, 6'(ks[i]), 3'(o), 2'(s), 1'b1);
          run(32'h1234_4076, 6'(ks[i]), 3'(o), 2'(s), 1'b0);
        end
      end

    run(32'h0000_0040, 6'd1, 3'd1, 2'd0, 1'b0);  // R4 top bit 0->1 sets V
    run(32'h0000_00C0, 6'd1, 3'd1, 2'd0, 1'b0);  // R4 top bit stays 1, V clear
    run(32'h0000_0000, 6'd40, 3'd1, 2'd2, 1'b1); // R4 zero operand
    run(32'hFFFF_FF80, 6'd3, 3'd0, 2'd0, 1'b0);  // R3 byte sign fill
    run(32'h0000_0001, 6'd9, 3'd5, 2'd0, 1'b0);  // R6 full ring returns operand

    for (int i = 0; i < 3000; i++)
      run($urandom, 6'($urandom), 3'($urandom), 2'($urandom), 1'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule